// File: doc/BRIEF.md
# Selectable Byte-Stream CRC Engine

This block works out a cyclic redundancy check over a stream of bytes, one byte per clock. At run time it selects one of three algorithms. The first is a 16-bit reflected CRC with a one's-complemented result, in the ISO/IEC 3309 style. The second is a legacy 16-bit variant that uses the same polynomial but does not complement the result. The third is an 8-bit CRC. A start pulse latches the mode bits and loads the CRC register from two 8-bit preset inputs. The engine then absorbs bytes from a valid/ready input stream until it takes a byte flagged as last. On the next cycle it publishes a two-byte result, a ready flag and an error flag.

In check mode the stream is a received frame whose trailing one or two bytes carry the CRC. Payload bytes pass through to a valid/ready output stream. The engine always holds back the newest 2 bytes in 16-bit mode, or the newest 1 byte in 8-bit mode, because any of them may turn out to be the CRC. When the frame ends, the register is compared with the good-frame residue of the selected algorithm. On a match the held bytes are dropped. On a mismatch the error flag is set and the held bytes are sent out after the payload.

Back-pressure rules:
- In calculate mode the input is always ready while a calculation runs.
- In check mode, once the holdback buffer is full, a new input byte can be taken only in the same cycle that the oldest held byte leaves downstream. Input readiness then follows `out_ready`.
- `out_valid` never depends on `out_ready`.
- A byte offered on the output stays stable until it is taken.

Top module: `crc_cop`

## Requirements
- R1: After reset, `res_ready`, `res_err`, `res_lo`, `res_hi`, `in_ready` and `out_valid` are all 0.
- R2: A `start` pulse while idle clears `res_ready` and `res_err`, latches `cfg_narrow`, `cfg_iso` and `cfg_check`, and loads the CRC register from the presets (`{preset_hi, preset_lo}`, or `preset_lo` alone in 8-bit mode). A `start` pulse while a calculation is running is ignored, and so are preset and mode changes at that time.
- R3: While running with no downstream back-pressure, one input byte is accepted in every cycle that `in_valid` is high. The byte accepted with `in_last` = 1 ends the stream.
- R4: `res_ready` is low while a calculation runs and rises in the cycle after the last byte is accepted. From then until the next accepted `start`, `res_lo`, `res_hi` and `res_err` hold steady and `in_ready` stays low.
- R5: With `cfg_narrow` = 0 and `cfg_iso` = 1, the engine uses the reflected polynomial 8408h, LSB of each byte first, and the result is the one's complement of the register, with bits 7:0 in `res_lo` and bits 15:8 in `res_hi`. For the ASCII bytes "123456789" with preset FFFFh the result is 906Eh.
- R6: With `cfg_narrow` = 0 and `cfg_iso` = 0, the engine uses the same polynomial and bit order with no final complement. For "123456789" with preset FFFFh the result is 6F91h.
- R7: With `cfg_narrow` = 1, the engine uses the 8-bit polynomial 1Dh, MSB first, with `preset_lo` as the initial value, and the result is not complemented. `res_lo` carries the CRC, `res_hi` reads 00h, and `preset_hi` has no effect. For "123456789" with preset FFh the result is B4h.
- R8: With `cfg_check` = 1, every byte except the trailing 2 (16-bit) or 1 (8-bit) leaves on the output stream, in order and unchanged.
- R9: In check mode, a register residue equal to F0B8h (ISO mode), 0000h (legacy mode) or 00h (8-bit mode) gives `res_err` = 0, and the trailing CRC bytes are never sent out.
- R10: In check mode any other residue gives `res_err` = 1, and the held trailing bytes are sent out in order after the payload.
- R11: In check mode with the holdback buffer full and `out_ready` low, `in_ready` is low, and the offered output byte (the oldest held byte) stays valid and unchanged.
- R12: In calculate mode (`cfg_check` = 0), `out_valid` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation (honoured only when idle) |
| cfg_narrow | input | 1 | 1: 8-bit CRC, 0: 16-bit CRC |
| cfg_iso | input | 1 | 16-bit algorithm: 1 complemented (ISO/IEC 3309 style), 0 legacy |
| cfg_check | input | 1 | 1: check a received frame, 0: calculate |
| preset_lo | input | 8 | Initial value, low byte |
| preset_hi | input | 8 | Initial value, high byte (16-bit mode only) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Engine accepts the input byte |
| out_valid | output | 1 | Forwarded byte valid (check mode) |
| out_data | output | 8 | Forwarded byte |
| out_ready | input | 1 | Downstream accepts the forwarded byte |
| res_lo | output | 8 | Result bits 7:0 |
| res_hi | output | 8 | Result bits 15:8 (00h in 8-bit mode) |
| res_ready | output | 1 | Result and error flag are valid |
| res_err | output | 1 | Check mode: residue mismatch |

## Verification
A wrong bit in the CRC register carries through every later byte. It shows up on `res_lo`/`res_hi` in the cycle after the last byte, and in check mode as a wrongly set `res_err` together with two extra bytes on the output stream. A corrupted holdback count or slot shows up earlier. The count error appears on the output stream as a byte forwarded one position too soon or too late, in the very cycle the buffer should fill. The slot error appears as a wrong value on `out_data` in the cycle that slot is forwarded. A control state stuck in running keeps `res_ready` low past the cycle after `in_last`, and the bench tests that edge exactly.

// File: rtl/crc_cop_pkg.sv
package crc_cop_pkg;

  localparam int BYTE_W     = 8;
  localparam int CRC_W      = 16;
  localparam int HOLD_DEPTH = CRC_W / BYTE_W;
  localparam int HOLD_CW    = $clog2(HOLD_DEPTH + 1);

  localparam logic [CRC_W-1:0]  POLY_REFL16  = 16'h8408;
  localparam logic [BYTE_W-1:0] POLY_NARROW  = 8'h1D;
  localparam logic [CRC_W-1:0]  RESID_ISO    = 16'hF0B8;
  localparam logic [CRC_W-1:0]  RESID_LEGACY = 16'h0000;
  localparam logic [BYTE_W-1:0] RESID_NARROW = 8'h00;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2
  } cop_state_e;

  typedef struct packed {
    logic narrow;
    logic iso;
    logic check;
  } cop_mode_t;

endpackage

// File: rtl/crc_cop_step.sv
module crc_cop_step
  import crc_cop_pkg::*;
#(
  parameter logic [CRC_W-1:0]  POLY16 = POLY_REFL16,
  parameter logic [BYTE_W-1:0] POLY8  = POLY_NARROW
) (
  input  logic              narrow,
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] data,
  output logic [CRC_W-1:0]  crc_out
);

  logic [CRC_W-1:0]  wide_chain   [BYTE_W+1];
  logic [BYTE_W-1:0] narrow_chain [BYTE_W+1];

  assign wide_chain[0]   = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, data};
  assign narrow_chain[0] = crc_in[BYTE_W-1:0] ^ data;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_bit
    // reflected 16-bit: LSB leaves first
    assign wide_chain[g+1] = wide_chain[g][0]
                           ? ((wide_chain[g] >> 1) ^ POLY16)
                           : (wide_chain[g] >> 1);
    // 8-bit: MSB leaves first
    assign narrow_chain[g+1] = narrow_chain[g][BYTE_W-1]
                             ? ((narrow_chain[g] << 1) ^ POLY8)
                             : (narrow_chain[g] << 1);
  end

  assign crc_out = narrow ? {{(CRC_W-BYTE_W){1'b0}}, narrow_chain[BYTE_W]}
                          : wide_chain[BYTE_W];

endmodule

// File: rtl/crc_cop_result.sv
module crc_cop_result
  import crc_cop_pkg::*;
(
  input  logic              narrow,
  input  logic              iso,
  input  logic [CRC_W-1:0]  crc_val,
  output logic [BYTE_W-1:0] fin_lo,
  output logic [BYTE_W-1:0] fin_hi,
  output logic              fin_ok
);

  always_comb begin
    if (narrow) begin
      fin_lo = crc_val[BYTE_W-1:0];
      fin_hi = '0;
      fin_ok = (crc_val[BYTE_W-1:0] == RESID_NARROW);
    end else if (iso) begin
      fin_lo = ~crc_val[BYTE_W-1:0];
      fin_hi = ~crc_val[CRC_W-1:BYTE_W];
      fin_ok = (crc_val == RESID_ISO);
    end else begin
      fin_lo = crc_val[BYTE_W-1:0];
      fin_hi = crc_val[CRC_W-1:BYTE_W];
      fin_ok = (crc_val == RESID_LEGACY);
    end
  end

endmodule

// File: rtl/crc_cop_holdback.sv
module crc_cop_holdback
  import crc_cop_pkg::*;
#(
  parameter int DEPTH = HOLD_DEPTH,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic [CW-1:0]     limit,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic [CW-1:0]     count
);

  logic [BYTE_W-1:0] slot_q [DEPTH];
  logic [BYTE_W-1:0] slot_d [DEPTH];
  logic [CW-1:0]     cnt_q, cnt_d, wr_idx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    cnt_d = cnt_q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i+1];
      slot_d[DEPTH-1] = '0;
      cnt_d = cnt_q - 1'b1;
    end
    wr_idx = cnt_d;
    if (push && (wr_idx < CW'(DEPTH))) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == wr_idx) slot_d[i] = push_data;
      end
      cnt_d = cnt_d + 1'b1;
    end
    if (clear) cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

  assign head  = slot_q[0];
  assign count = cnt_q;

  a_r11_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

  a_r8_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

endmodule

// File: rtl/crc_cop.sv
module crc_cop
  import crc_cop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_narrow,
  input  logic              cfg_iso,
  input  logic              cfg_check,
  input  logic [BYTE_W-1:0] preset_lo,
  input  logic [BYTE_W-1:0] preset_hi,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] res_lo,
  output logic [BYTE_W-1:0] res_hi,
  output logic              res_ready,
  output logic              res_err
);

  cop_state_e        state_q;
  cop_mode_t         mode_q;
  logic [CRC_W-1:0]  crc_q, crc_next;
  logic [BYTE_W-1:0] fin_lo, fin_hi;
  logic              fin_ok;

  logic [HOLD_CW-1:0] hb_limit, hb_count;
  logic [BYTE_W-1:0]  hb_head;
  logic               hb_full, hb_push, hb_pop, hb_clear;
  logic               take_start, take_byte, take_last, pass_through, flush_pop;

  // ---------------- datapath ----------------
  crc_cop_step u_step (
    .narrow  (mode_q.narrow),
    .crc_in  (crc_q),
    .data    (in_data),
    .crc_out (crc_next)
  );

  crc_cop_result u_result (
    .narrow  (mode_q.narrow),
    .iso     (mode_q.iso),
    .crc_val (crc_next),
    .fin_lo  (fin_lo),
    .fin_hi  (fin_hi),
    .fin_ok  (fin_ok)
  );

  crc_cop_holdback #(.DEPTH(HOLD_DEPTH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (hb_clear),
    .limit     (hb_limit),
    .push      (hb_push),
    .push_data (in_data),
    .pop       (hb_pop),
    .head      (hb_head),
    .count     (hb_count)
  );

  // ---------------- handshakes ----------------
  assign hb_limit = mode_q.narrow ? HOLD_CW'(1) : HOLD_CW'(HOLD_DEPTH);
  assign hb_full  = (hb_count == hb_limit);

  assign in_ready  = (state_q == ST_RUN) &&
                     (!mode_q.check || !hb_full || out_ready);
  assign take_start = (state_q == ST_IDLE) && start;
  assign take_byte  = in_valid && in_ready;
  assign take_last  = take_byte && in_last;

  assign pass_through = take_byte && mode_q.check && hb_full;
  assign flush_pop    = (state_q == ST_FLUSH) && (hb_count != '0) && out_ready;

  assign out_valid = ((state_q == ST_RUN) && in_valid && mode_q.check && hb_full) ||
                     ((state_q == ST_FLUSH) && (hb_count != '0));
  assign out_data  = hb_head;

  assign hb_push  = take_byte && mode_q.check;
  assign hb_pop   = pass_through || flush_pop;
  // good frame (or calc mode): trailing bytes are discarded
  assign hb_clear = take_start || (take_last && !(mode_q.check && !fin_ok));

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mode_q    <= '0;
      crc_q     <= '0;
      res_lo    <= '0;
      res_hi    <= '0;
      res_ready <= 1'b0;
      res_err   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_RUN;
            mode_q    <= '{narrow: cfg_narrow, iso: cfg_iso, check: cfg_check};
            crc_q     <= cfg_narrow ? {{(CRC_W-BYTE_W){1'b0}}, preset_lo}
                                    : {preset_hi, preset_lo};
            res_ready <= 1'b0;
            res_err   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (take_byte) begin
            crc_q <= crc_next;
            if (in_last) begin
              res_lo    <= fin_lo;
              res_hi    <= fin_hi;
              res_ready <= 1'b1;
              res_err   <= mode_q.check && !fin_ok;
              state_q   <= (mode_q.check && !fin_ok) ? ST_FLUSH : ST_IDLE;
            end
          end
        end
        ST_FLUSH: begin
          if ((hb_count == '0) || ((hb_count == HOLD_CW'(1)) && out_ready))
            state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  a_r4_no_ready_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> !res_ready);

  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ready && !take_start) |=>
      (res_ready && $stable(res_lo) && $stable(res_hi) && $stable(res_err)));

  a_r12_quiet_in_calc: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q.check |-> !out_valid);

  a_r11_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FLUSH) && out_valid && !out_ready) |=>
      (out_valid && $stable(out_data)));

  a_r10_err_needs_check: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> mode_q.check);

  a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && start && !take_byte) |=> $stable(crc_q));

endmodule

// File: tb/test_crc_cop.sv
module test_crc_cop;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       cfg_narrow = 1'b0, cfg_iso = 1'b0, cfg_check = 1'b0;
  logic [7:0] preset_lo = 8'h00, preset_hi = 8'h00;
  logic       in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;
  logic [7:0] res_lo, res_hi;
  logic       res_ready, res_err;

  always #5 clk = ~clk;

  crc_cop i_crc_cop (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_narrow(cfg_narrow), .cfg_iso(cfg_iso), .cfg_check(cfg_check),
    .preset_lo(preset_lo), .preset_hi(preset_hi),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .res_lo(res_lo), .res_hi(res_hi), .res_ready(res_ready), .res_err(res_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] tx  [64];
  logic [7:0] got [64];
  int got_n = 0;
  int last_stalls = 0;
  logic ready_after_start = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // output stream monitor, sampled mid-cycle
  always begin
    @(negedge clk);
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (got_n < 64) got[got_n] = out_data;
      got_n++;
    end
  end

  function automatic logic [15:0] ref16(input logic [15:0] init, input int n);
    logic [15:0] r = init;
    for (int i = 0; i < n; i++) begin
      r = r ^ {8'h00, tx[i]};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] ref8(input logic [7:0] init, input int n);
    logic [7:0] r = init;
    for (int i = 0; i < n; i++) begin
      r = r ^ tx[i];
      for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
    end
    return r;
  endfunction

  task automatic load_digits();
    for (int i = 0; i < 9; i++) tx[i] = 8'h31 + 8'(i);
  endtask

  // drive one stream; busy_at >= 0 pulses start with altered config mid-stream
  task automatic run_frame(input bit nar, input bit iso, input bit chkm,
                           input logic [7:0] plo, input logic [7:0] phi,
                           input int n, input int busy_at);
    got_n = 0;
    last_stalls = 0;
    @(negedge clk);
    cfg_narrow = nar; cfg_iso = iso; cfg_check = chkm;
    preset_lo = plo; preset_hi = phi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ready_after_start = res_ready;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      in_valid = 1'b1;
      in_data  = tx[i];
      in_last  = (i == n - 1);
      start    = (i == busy_at);
      if (i == busy_at) begin
        preset_lo = 8'h00; preset_hi = 8'h00; cfg_narrow = ~nar; cfg_check = ~chkm;
      end
      #2;
      while (!in_ready) begin
        last_stalls++;
        @(negedge clk);
        #2;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; start = 1'b0;
    #1;
  endtask

  task automatic cmp_got(input string req, input int n_exp);
    chk(got_n == n_exp, req, "forwarded count", got_n, n_exp);
    for (int i = 0; i < n_exp && i < got_n; i++)
      chk(got[i] == tx[i], req, "forwarded byte", got[i], tx[i]);
  endtask

  task automatic t_reset();
    chk(res_ready == 1'b0, "R1", "res_ready", res_ready, 0);
    chk(res_err == 1'b0, "R1", "res_err", res_err, 0);
    chk({res_hi, res_lo} == 16'h0, "R1", "result", {res_hi, res_lo}, 0);
    chk(in_ready == 1'b0, "R1", "in_ready", in_ready, 0);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
  endtask

  task automatic t_iso_vector();
    load_digits();
    run_frame(1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 9, -1);
    chk(res_ready == 1'b1, "R4", "ready after last", res_ready, 1);
    chk({res_hi, res_lo} == 16'h906E, "R5", "iso check value", {res_hi, res_lo}, 16'h906E);
    chk(last_stalls == 0, "R3", "stalls", last_stalls, 0);
    chk(got_n == 0, "R12", "calc output", got_n, 0);
  endtask

  task automatic t_legacy_vector();
    load_digits();
    run_frame(1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF, 9, -1);
    chk(ready_after_start == 1'b0, "R2", "ready cleared by start", ready_after_start, 0);
    chk({res_hi, res_lo} == 16'h6F91, "R6", "legacy check value", {res_hi, res_lo}, 16'h6F91);
  endtask

  task automatic t_narrow_vector();
    load_digits();
    run_frame(1'b1, 1'b0, 1'b0, 8'hFF, 8'hA5, 9, -1);
    chk(res_lo == 8'hB4, "R7", "crc8 check value", res_lo, 8'hB4);
    chk(res_hi == 8'h00, "R7", "crc8 high byte", res_hi, 0);
    run_frame(1'b1, 1'b1, 1'b0, 8'hFF, 8'h3C, 9, -1);
    chk(res_lo == 8'hB4, "R7", "preset_hi ignored", res_lo, 8'hB4);
  endtask

  task automatic t_patterns();
    logic [15:0] e16;
    logic [7:0]  e8;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 5 + k; i++) tx[i] = 8'((i * 37 + k * 91) ^ 8'h5A);
      e16 = ~ref16({8'(k * 17), 8'hC3 - 8'(k)}, 5 + k);
      run_frame(1'b0, 1'b1, 1'b0, 8'hC3 - 8'(k), 8'(k * 17), 5 + k, -1);
      chk({res_hi, res_lo} == e16, "R5", "iso pattern", {res_hi, res_lo}, e16);
      e16 = ref16(16'h1234, 5 + k);
      run_frame(1'b0, 1'b0, 1'b0, 8'h34, 8'h12, 5 + k, -1);
      chk({res_hi, res_lo} == e16, "R6", "legacy pattern", {res_hi, res_lo}, e16);
      e8 = ref8(8'(k * 29 + 1), 5 + k);
      run_frame(1'b1, 1'b0, 1'b0, 8'(k * 29 + 1), 8'hEE, 5 + k, -1);
      chk(res_lo == e8, "R7", "crc8 pattern", res_lo, e8);
    end
    e8 = ref8(8'h00, 1);
    run_frame(1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1, -1);
    chk(res_lo == e8, "R7", "single byte", res_lo, e8);
  endtask

  task automatic t_check_good();
    logic [15:0] c;
    for (int i = 0; i < 6; i++) tx[i] = 8'hA0 + 8'(i * 3);
    c = ~ref16(16'hFFFF, 6); tx[6] = c[7:0]; tx[7] = c[15:8];
    run_frame(1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 8, -1);
    repeat (3) @(negedge clk);
    chk(res_err == 1'b0, "R9", "iso good residue", res_err, 0);
    cmp_got("R8", 6);
    c = ref16(16'hBEEF, 6); tx[6] = c[7:0]; tx[7] = c[15:8];
    run_frame(1'b0, 1'b0, 1'b1, 8'hEF, 8'hBE, 8, -1);
    repeat (3) @(negedge clk);
    chk(res_err == 1'b0, "R9", "legacy good residue", res_err, 0);
    cmp_got("R8", 6);
    tx[6] = ref8(8'h7E, 6);
    run_frame(1'b1, 1'b0, 1'b1, 8'h7E, 8'h00, 7, -1);
    repeat (3) @(negedge clk);
    chk(res_err == 1'b0, "R9", "crc8 good residue", res_err, 0);
    cmp_got("R8", 6);
  endtask

  task automatic t_check_bad();
    logic [15:0] c;
    for (int i = 0; i < 5; i++) tx[i] = 8'h11 * 8'(i + 1);
    c = ~ref16(16'hFFFF, 5); tx[5] = c[7:0]; tx[6] = c[15:8] ^ 8'h01;
    run_frame(1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 7, -1);
    chk(res_err == 1'b1, "R10", "iso bad flagged", res_err, 1);
    repeat (4) @(negedge clk);
    cmp_got("R10", 7);
    tx[5] = ref8(8'h00, 5) ^ 8'h80;
    run_frame(1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 6, -1);
    chk(res_err == 1'b1, "R10", "crc8 bad flagged", res_err, 1);
    repeat (4) @(negedge clk);
    cmp_got("R10", 6);
  endtask

  task automatic t_backpressure();
    logic [15:0] c;
    for (int i = 0; i < 4; i++) tx[i] = 8'hD0 + 8'(i);
    c = ~ref16(16'hFFFF, 4); tx[4] = c[7:0]; tx[5] = c[15:8];
    out_ready = 1'b0;
    fork
      run_frame(1'b0, 1'b1, 1'b1, 8'hFF, 8'hFF, 6, -1);
    join_none
    repeat (4) @(negedge clk);
    #3;
    chk(in_ready == 1'b0, "R11", "in_ready when full", in_ready, 0);
    chk(out_valid == 1'b1, "R11", "out_valid when full", out_valid, 1);
    chk(out_data == tx[0], "R11", "oldest byte offered", out_data, tx[0]);
    @(negedge clk);
    #3;
    chk(out_data == tx[0], "R11", "offered byte stable", out_data, tx[0]);
    @(negedge clk);
    out_ready = 1'b1;
    wait (res_ready == 1'b1);
    repeat (3) @(negedge clk);
    chk(res_err == 1'b0, "R9", "good after stall", res_err, 0);
    cmp_got("R11", 4);
  endtask

  task automatic t_busy_start_and_hold();
    logic [15:0] r0;
    load_digits();
    run_frame(1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 9, 3);
    chk({res_hi, res_lo} == 16'h906E, "R2", "busy start ignored", {res_hi, res_lo}, 16'h906E);
    r0 = {res_hi, res_lo};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'(k * 77); preset_lo = 8'(k); cfg_narrow = k[0];
      #2;
      chk(in_ready == 1'b0, "R4", "no intake after done", in_ready, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    #2;
    chk({res_hi, res_lo} == r0, "R4", "result held", {res_hi, res_lo}, r0);
    chk(res_ready == 1'b1, "R4", "ready held", res_ready, 1);
  endtask

  initial begin
    #2000000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    t_reset();
    t_iso_vector();
    t_legacy_vector();
    t_narrow_vector();
    t_patterns();
    t_check_good();
    t_check_bad();
    t_backpressure();
    t_busy_start_and_hold();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule